// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel with a selectable operating mode. Software selects a mode with a control write and loads a 16-bit start value with two byte writes, low byte first. The channel then decrements once per rising clock edge and drives a single output line. Depending on the mode, that line produces a terminal-count flag, a gate-triggered one-shot pulse, a one-cycle rate pulse, or a near-square wave at the clock rate divided by the loaded value.

A gate input qualifies counting in the free-running modes and starts or restarts the pulse in the one-shot mode. A read port continuously shows the live counter and a status byte. The status byte carries the output level, a flag saying that a written value has not yet reached the counter, the byte-order state and the stored mode code. A count value of zero stands for 65536.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low, the counter reads 0, the stored mode code is 0, the next count byte is taken as the low byte and the not-yet-loaded flag is set, so the status byte reads 0x40.
- R2: Count bytes alternate low then high, and the counter value is {high, low}. Status bit 5 is 1 while a high byte is awaited. A control write returns the byte order to "low next", and it takes priority over a count write in the same cycle.
- R3: Mode 0 (code 0): a control write drives the output low. A completed count write loads the counter on the same edge, drives the output low and restarts counting. The counter decrements only while the gate is high. The output goes high on the edge where the counter goes from 1 to 0 and stays high, with counting stopped, until the next count or control write.
- R4: Mode 1 (code 1): a control write drives the output high. A gate rising edge, once a count has been written, loads the counter and drives the output low on the clock edge that samples the edge. The counter then decrements whatever the gate level, and the output returns high as it goes from 1 to 0, giving a low pulse of N clocks.
- R5: In mode 1, a count written during a pulse changes neither the running counter nor the output, and it sets the not-yet-loaded flag. The next gate rising edge reloads the newest count and keeps the output low until that count expires.
- R6: Mode 2 (code 2 or 6): the first count after a control write loads at once with the output high. While the gate is high, the output is low only for the clock in which the counter holds 1, and the counter then reloads, giving a period of N clocks. While the gate is low, the counter holds and the output is high.
- R7: In mode 2, a count written while running sets the not-yet-loaded flag, takes effect at the next reload and clears the flag there.
- R8: Mode 3 (code 3 or 7) with N of at least 2: the output is high for ceil(N/2) clocks and low for floor(N/2) clocks, starting high on the load edge, and repeats.
- R9: Codes 6 and 7 behave as codes 2 and 3. Codes 4 and 5 park the channel: the output is high, the counter is frozen and count writes have no visible effect.
- R10: A loaded count of 0 counts as 65536: in mode 0 the output goes high 65536 counting clocks after the load.
- R11: Status layout: bit 7 is the output level, bit 6 is the not-yet-loaded flag, bit 5 is the awaiting-high-byte flag, bits 4:3 are 0 and bits 2:0 are the stored mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_i | input | 1 | Gate: enables counting (modes 0, 2, 3), triggers on rising edge (mode 1) |
| ctl_wr_i | input | 1 | Control write strobe, one cycle |
| ctl_code_i | input | 3 | Mode code captured by a control write |
| cnt_wr_i | input | 1 | Count byte write strobe, one cycle |
| cnt_byte_i | input | 8 | Count byte, low byte then high byte |
| out_o | output | 1 | Timer output line |
| cnt_o | output | 16 | Live counter value |
| status_o | output | 8 | Status byte, layout in R11 |

## Verification
The properties assume that the gate and the write strobes are synchronous to the clock. They also assume that rate and square-wave modes are only given counts of 2 or more, since a count of 1 has no valid low or high phase there. The stimulus changes every input on the falling clock edge. It loads only values between 3 and 9 in those two modes, and it uses 0 only in the terminal-count mode to reach the 65536 case.

// File: rtl/pit_pkg.sv
// Package: shared mode type and mode-code decoding for the timer channel.
// Assumes a 3-bit mode code; codes 4 and 5 map to a parked state.
package pit_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_PARK    = 3'd4
    } pit_mode_e;

    // Map a raw code to a mode; the top bit is ignored for the divider modes.
    function automatic pit_mode_e decode_mode(input logic [MODE_W-1:0] code);
        pit_mode_e m;
        case (code[1:0])
            2'b10:   m = MD_RATE;
            2'b11:   m = MD_SQUARE;
            2'b01:   m = code[2] ? MD_PARK : MD_ONESHOT;
            default: m = code[2] ? MD_PARK : MD_TERM;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pit_wr_port.sv
// Module: write port. Holds the mode code and assembles the count word from
// two byte writes (low first). Issues a one-cycle word strobe on the high byte.
// Assumes strobes are one clock wide; a control write wins over a count write.
module pit_wr_port
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic [MODE_W-1:0] ctl_code_i,
    input  logic              cnt_wr_i,
    input  logic [BYTE_W-1:0] cnt_byte_i,
    output logic [MODE_W-1:0] code_o,
    output pit_mode_e         mode_o,
    output pit_mode_e         mode_nxt_o,
    output logic              hi_wait_o,
    output logic              word_stb_o,
    output logic [WORD_W-1:0] word_o
);

    logic [MODE_W-1:0] code_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_wait_q;

    // Capture the mode code and track which byte of the count comes next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= '0;
            lo_q      <= '0;
            hi_wait_q <= 1'b0;
        end else if (ctl_wr_i) begin
            code_q    <= ctl_code_i;
            hi_wait_q <= 1'b0;
        end else if (cnt_wr_i) begin
            if (!hi_wait_q) begin
                lo_q <= cnt_byte_i;
            end
            hi_wait_q <= ~hi_wait_q;
        end
    end

    // Present the finished word and decoded modes to the counter core.
    always_comb begin
        word_stb_o = cnt_wr_i & hi_wait_q & ~ctl_wr_i;
        word_o     = {cnt_byte_i, lo_q};
        code_o     = code_q;
        hi_wait_o  = hi_wait_q;
        mode_o     = decode_mode(code_q);
        mode_nxt_o = decode_mode(ctl_code_i);
    end

endmodule

// File: rtl/pit_gate_edge.sv
// Module: gate conditioning. Passes the gate level and flags a rising edge.
// Assumes the gate is synchronous to clk. Reset treats the gate as high
// so that a gate already high at reset release is not taken as an edge.
module pit_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic level_o,
    output logic rise_o
);

    logic gate_q;

    // Remember the previous gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= gate_i;
        end
    end

    // Level and rising-edge outputs.
    always_comb begin
        level_o = gate_i;
        rise_o  = gate_i & ~gate_q;
    end

endmodule

// File: rtl/pit_count_core.sv
// Module: counting element and output logic for all modes.
// Assumes counts of at least 2 in the rate and square modes; a zero count
// stands for 2**CNT_W. A control write stops the counter and presets OUT.
module pit_count_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pit_mode_e        mode_i,
    input  logic             ctl_stb_i,
    input  pit_mode_e        mode_nxt_i,
    input  logic             word_stb_i,
    input  logic [CNT_W-1:0] word_i,
    input  logic             gate_lvl_i,
    input  logic             gate_rise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_o,
    output logic             null_o
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
    localparam logic [CNT_W:0]   ONE_X = (CNT_W + 1)'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             out_q;
    logic             null_q;
    logic             run_q;
    logic             armed_q;
    logic             sq_hi_q;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] nxt_rld;
    logic             at_one;
    logic             at_two;

    // Widen a count so that zero means 2**CNT_W.
    function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] w);
        return (w == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, w};
    endfunction

    // Length of the high half of a square-wave period: ceil(N/2).
    function automatic logic [CNT_W-1:0] half_hi(input logic [CNT_W-1:0] w);
        logic [CNT_W:0] s;
        s = widen(w) + ONE_X;
        return s[CNT_W:1];
    endfunction

    // Length of the low half of a square-wave period: floor(N/2).
    function automatic logic [CNT_W-1:0] half_lo(input logic [CNT_W-1:0] w);
        logic [CNT_W:0] n;
        n = widen(w);
        return n[CNT_W:1];
    endfunction

    // Decrement value, terminal tests and the reload source.
    always_comb begin
        cnt_dec = cnt_q - ONE;
        at_one  = (cnt_q == ONE);
        at_two  = (cnt_q == TWO);
        nxt_rld = word_stb_i ? word_i : rld_q;
    end

    // Counter, output and load-flag update for every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            out_q   <= 1'b0;
            null_q  <= 1'b1;
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            sq_hi_q <= 1'b1;
        end else if (ctl_stb_i) begin
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            null_q  <= 1'b1;
            sq_hi_q <= 1'b1;
            out_q   <= (mode_nxt_i != MD_TERM);
        end else begin
            if (word_stb_i) begin
                rld_q <= word_i;
            end
            case (mode_i)
                MD_TERM: begin
                    if (word_stb_i) begin
                        cnt_q  <= word_i;
                        out_q  <= 1'b0;
                        null_q <= 1'b0;
                        run_q  <= 1'b1;
                    end else if (run_q && gate_lvl_i) begin
                        cnt_q <= cnt_dec;
                        if (at_one) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end
                    end
                end
                MD_ONESHOT: begin
                    if (word_stb_i) begin
                        null_q  <= 1'b1;
                        armed_q <= 1'b1;
                    end
                    if (gate_rise_i && (armed_q || word_stb_i)) begin
                        cnt_q  <= nxt_rld;
                        out_q  <= 1'b0;
                        null_q <= 1'b0;
                        run_q  <= 1'b1;
                    end else if (run_q) begin
                        cnt_q <= cnt_dec;
                        if (at_one) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end
                    end
                end
                MD_RATE: begin
                    if (word_stb_i && !run_q) begin
                        cnt_q  <= word_i;
                        out_q  <= 1'b1;
                        null_q <= 1'b0;
                        run_q  <= 1'b1;
                    end else if (run_q) begin
                        if (word_stb_i) begin
                            null_q <= 1'b1;
                        end
                        if (!gate_lvl_i) begin
                            out_q <= 1'b1;
                        end else if (at_one) begin
                            cnt_q  <= nxt_rld;
                            out_q  <= 1'b1;
                            null_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_dec;
                            out_q <= ~at_two;
                        end
                    end
                end
                MD_SQUARE: begin
                    if (word_stb_i && !run_q) begin
                        cnt_q   <= half_hi(word_i);
                        out_q   <= 1'b1;
                        sq_hi_q <= 1'b1;
                        null_q  <= 1'b0;
                        run_q   <= 1'b1;
                    end else if (run_q) begin
                        if (word_stb_i) begin
                            null_q <= 1'b1;
                        end
                        if (!gate_lvl_i) begin
                            out_q <= 1'b1;
                        end else if (at_one) begin
                            sq_hi_q <= ~sq_hi_q;
                            out_q   <= ~sq_hi_q;
                            cnt_q   <= sq_hi_q ? half_lo(nxt_rld) : half_hi(nxt_rld);
                            null_q  <= 1'b0;
                        end else begin
                            cnt_q <= cnt_dec;
                            out_q <= sq_hi_q;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Drive the outputs from state.
    always_comb begin
        cnt_o  = cnt_q;
        out_o  = out_q;
        null_o = null_q;
    end

endmodule

// File: rtl/pit_channel.sv
// Module: top of one timer channel. Joins the write port, gate conditioning
// and counting core, and assembles the status byte.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_i,
    input  logic              ctl_wr_i,
    input  logic [MODE_W-1:0] ctl_code_i,
    input  logic              cnt_wr_i,
    input  logic [BYTE_W-1:0] cnt_byte_i,
    output logic              out_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        status_o
);

    logic [MODE_W-1:0] code;
    pit_mode_e         mode;
    pit_mode_e         mode_nxt;
    logic              hi_wait;
    logic              word_stb;
    logic [CNT_W-1:0]  word;
    logic              gate_lvl;
    logic              gate_rise;
    logic              null_flag;

    pit_wr_port #(.BYTE_W(BYTE_W)) wr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr_i),
        .ctl_code_i (ctl_code_i),
        .cnt_wr_i   (cnt_wr_i),
        .cnt_byte_i (cnt_byte_i),
        .code_o     (code),
        .mode_o     (mode),
        .mode_nxt_o (mode_nxt),
        .hi_wait_o  (hi_wait),
        .word_stb_o (word_stb),
        .word_o     (word)
    );

    pit_gate_edge gate_i_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_i  (gate_i),
        .level_o (gate_lvl),
        .rise_o  (gate_rise)
    );

    pit_count_core #(.CNT_W(CNT_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .ctl_stb_i   (ctl_wr_i),
        .mode_nxt_i  (mode_nxt),
        .word_stb_i  (word_stb),
        .word_i      (word),
        .gate_lvl_i  (gate_lvl),
        .gate_rise_i (gate_rise),
        .cnt_o       (cnt_o),
        .out_o       (out_o),
        .null_o      (null_flag)
    );

    // Status byte: output level, load flag, byte order, mode code.
    always_comb begin
        status_o = {out_o, null_flag, hi_wait, 2'b00, code};
    end

endmodule

// File: rtl/pit_channel_chk.sv
// Module: property checker for the timer channel, bound to the top.
// Assumes inputs are synchronous to clk and rate/square counts are >= 2.
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_i,
    input logic             ctl_wr_i,
    input logic [2:0]       ctl_code_i,
    input logic             cnt_wr_i,
    input logic             out_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [7:0]       status_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2: a control write resets the byte order.
    p_ctl_resets_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> !status_o[5]);

    // R2: each count write without a control write flips the byte order.
    p_byte_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_i && !ctl_wr_i) |=> (status_o[5] != $past(status_o[5])));

    // R3: selecting mode 0 drives the output low.
    p_term_ctl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_code_i == 3'd0) |=> !out_o);

    // R3: in mode 0 the high output holds until a count or control write completes.
    p_term_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] == 3'd0 && out_o && !ctl_wr_i && !(cnt_wr_i && status_o[5]))
        |=> out_o);

    // R3: a completed count write in mode 0 loads the counter and drives OUT low.
    p_term_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] == 3'd0 && cnt_wr_i && status_o[5] && !ctl_wr_i)
        |=> (!status_o[6] && !out_o));

    // R5: with the gate low, a running one-shot keeps counting regardless of writes.
    p_oneshot_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] == 3'd1 && !out_o && !ctl_wr_i && !gate_i)
        |=> (cnt_o == ($past(cnt_o) - ONE)));

    // R6: in the rate mode the output is never low for two cycles in a row.
    p_rate_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1:0] == 2'b10 && !out_o && !ctl_wr_i) |=> out_o);

    // R9: parked codes freeze the counter and hold the output high.
    p_park_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:1] == 2'b10 && !ctl_wr_i) |=> ($stable(cnt_o) && out_o));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_i     (gate_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_code_i (ctl_code_i),
    .cnt_wr_i   (cnt_wr_i),
    .out_o      (out_o),
    .cnt_o      (cnt_o),
    .status_o   (status_o)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_code = 3'd0;
    logic        cnt_wr = 1'b0;
    logic [7:0]  cnt_byte = 8'h00;
    logic        out;
    logic [15:0] cnt;
    logic [7:0]  status;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pit_channel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (gate),
        .ctl_wr_i   (ctl_wr),
        .ctl_code_i (ctl_code),
        .cnt_wr_i   (cnt_wr),
        .cnt_byte_i (cnt_byte),
        .out_o      (out),
        .cnt_o      (cnt),
        .status_o   (status)
    );

    // Vector: [31] ctl, [30:28] code, [27] count write, [26:19] byte, [18] gate,
    // [17] expected out, [16] expected load flag, [15:0] expected counter.
    localparam int NV = 26;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'd0},
        {1'b0, 3'd0, 1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 16'd0},
        {1'b0, 3'd0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 16'd3},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'd2},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'd1},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd0},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd0},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'd0},
        {1'b1, 3'd6, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 16'd0},
        {1'b0, 3'd0, 1'b1, 8'h04, 1'b1, 1'b1, 1'b1, 16'd0},
        {1'b0, 3'd0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 16'd4},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd3},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd2},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'd1},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd4},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd3},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd2},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'd1},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd4},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'd4},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'd4},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd3},
        {1'b0, 3'd0, 1'b1, 8'h06, 1'b1, 1'b1, 1'b0, 16'd2},
        {1'b0, 3'd0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 16'd1},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd6},
        {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input logic [2:0] code);
        ctl_wr = 1'b1;
        ctl_code = code;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w);
        cnt_wr = 1'b1;
        cnt_byte = w[7:0];
        @(negedge clk);
        cnt_byte = w[15:8];
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic square_check(input string req, input int n);
        int hi;
        hi = (n + 1) / 2;
        for (int k = 0; k < 2 * n; k++) begin
            chk(req, 32'(out), 32'((k % n) < hi));
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] held;
        idle(3);
        rst_n = 1'b1;
        // R1 / R11: reset state.
        chk("R1 status", 32'(status), 32'h40);
        chk("R1 out", 32'(out), 32'd0);
        chk("R1 cnt", 32'(cnt), 32'd0);

        // Vector table: R3 (0..7), R6 (8..21), R7 (22..25).
        for (int i = 0; i < NV; i++) begin
            string req;
            {ctl_wr, ctl_code, cnt_wr, cnt_byte, gate} = VEC[i][31:18];
            @(negedge clk);
            req = (i < 8) ? "R3 vec" : ((i < 22) ? "R6 vec" : "R7 vec");
            chk(req, {out, status[6], cnt}, {VEC[i][17], VEC[i][16], VEC[i][15:0]});
        end
        ctl_wr = 1'b0;
        cnt_wr = 1'b0;

        // R2: byte order and reset of it by a control write.
        ctl(3'd0);
        cnt_wr = 1'b1; cnt_byte = 8'h02;
        @(negedge clk);
        cnt_wr = 1'b0;
        chk("R2 wait hi", 32'(status[5]), 32'd1);
        ctl(3'd0);
        chk("R2 order reset", 32'(status[5]), 32'd0);
        wr_word(16'h0102);
        chk("R2 word", 32'(cnt), 32'h0102);

        // R3: rewrite after terminal count restarts; gate low holds.
        ctl(3'd0);
        wr_word(16'd3);
        idle(3);
        chk("R3 terminal", {31'd0, out}, 32'd1);
        wr_word(16'd7);
        chk("R3 restart", {out, cnt}, {1'b0, 16'd7});
        gate = 1'b0;
        wr_word(16'd4);
        idle(3);
        chk("R3 gate hold", {out, cnt}, {1'b0, 16'd4});
        gate = 1'b1;
        idle(4);
        chk("R3 gate resume", {out, cnt}, {1'b1, 16'd0});

        // R4: one-shot start and pulse length.
        gate = 1'b0;
        ctl(3'd1);
        chk("R4 idle high", 32'(out), 32'd1);
        wr_word(16'd5);
        chk("R11 null pending", {status[7], status[6]}, 32'b11);
        idle(2);
        chk("R4 wait gate", 32'(out), 32'd1);
        gate = 1'b1;
        @(negedge clk);
        chk("R4 trigger", {out, status[6], cnt}, {1'b0, 1'b0, 16'd5});
        idle(4);
        chk("R4 pulse low", {out, cnt}, {1'b0, 16'd1});
        idle(1);
        chk("R4 pulse end", {out, cnt}, {1'b1, 16'd0});

        // R5: rewrite during a pulse, then retrigger.
        gate = 1'b0;
        wr_word(16'd8);
        gate = 1'b1;
        @(negedge clk);
        chk("R5 trigger", {out, cnt}, {1'b0, 16'd8});
        gate = 1'b0;
        idle(2);
        wr_word(16'd9);
        chk("R5 unaffected", {out, status[6], cnt}, {1'b0, 1'b1, 16'd4});
        gate = 1'b1;
        @(negedge clk);
        chk("R5 retrigger", {out, status[6], cnt}, {1'b0, 1'b0, 16'd9});
        idle(8);
        chk("R5 extended", {out, cnt}, {1'b0, 16'd1});
        idle(1);
        chk("R5 expire", 32'(out), 32'd1);

        // R8 / R9: square wave, even count with code 3, odd with alias 7.
        ctl(3'd3);
        wr_word(16'd4);
        square_check("R8 even", 4);
        ctl(3'd7);
        wr_word(16'd5);
        square_check("R9 alias R8 odd", 5);

        // R9: parked code ignores count writes.
        ctl(3'd4);
        held = cnt;
        wr_word(16'h0033);
        idle(3);
        chk("R9 park", {out, cnt}, {1'b1, held});
        chk("R11 code", 32'(status[2:0]), 32'd4);

        // R10: zero count lasts 65536 clocks.
        ctl(3'd0);
        wr_word(16'd0);
        chk("R10 load", {out, cnt}, {1'b0, 16'd0});
        idle(1);
        chk("R10 wrap", {out, cnt}, {1'b0, 16'hFFFF});
        idle(65534);
        chk("R10 near end", {out, cnt}, {1'b0, 16'd1});
        idle(1);
        chk("R10 end", {out, cnt}, {1'b1, 16'd0});

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule